// File: doc/BRIEF.md
# Dual-Strobe Parallel Link Transmitter

The block sends 18-bit words to a neighbouring chip over five data wires and two strobe wires. Each word is split into two 9-bit halves. Each half is sent as it is or inverted, whichever has fewer ones, and a tenth bit records that choice. The two resulting 10-bit codes go out as four 5-bit beats. The data wires use toggle-on-one (NRZI) line coding, and their state carries over from one transaction to the next.

The two strobes step through a Gray sequence of four edges. Each edge tells the receiver to take one beat. Stepping forward (A moves first) marks an ordinary data word. Stepping backward (B moves first) marks a control word. Two other short sequences need no word: two edges on A alone restart the line coding at zero, and two edges on B alone signal a link-status update.

The source offers a word with a valid/ready handshake and a control flag. Restart and status requests are level inputs that are taken under the same ready.

Top module: `strobe_link_tx`

## Requirements
- R1: After reset, `tx_ready` is 1, both strobes are 0 and `line_d` is 0. `tx_ready` is 1 only while no transaction is running, and then both strobes are 0. It goes to 0 in the cycle after a request is accepted.
- R2: Each 9-bit half (half 0 is `tx_word[8:0]`, half 1 is `tx_word[17:9]`) becomes a 10-bit code. If more than 4 of the half's bits are 1, bits [8:0] of the code are the inverted half and bit 9 is 1. Otherwise bits [8:0] are the half unchanged and bit 9 is 0.
- R3: The four beats go out in this order: code 0 bits [4:0], code 0 bits [9:5], code 1 bits [4:0], code 1 bits [9:5]. Bit i of a beat goes to `line_d[i]`.
- R4: For each beat, every `line_d` wire whose beat bit is 1 toggles, and every other wire keeps its level.
- R5: `line_d` is updated at least one cycle before the strobe edge that marks the beat, and it does not change in the cycle in which a strobe changes.
- R6: A data word (`tx_is_ctrl`=0) drives {`line_sa`,`line_sb`} through 10, 11, 01, 00.
- R7: A control word (`tx_is_ctrl`=1) drives {`line_sa`,`line_sb`} through 01, 11, 10, 00. Its beats follow R2 to R4 in the same way as a data word.
- R8: A restart request produces exactly two edges, both on `line_sa` (10, then 00). `line_d` is 0 at both edges, and the next word toggles from that zero state.
- R9: A status request produces exactly two edges, both on `line_sb` (01, then 00), and `line_d` keeps its value throughout.
- R10: In any one cycle, at most one strobe changes.
- R11: When several requests are present at acceptance, only one is served: restart first, then status, then the word. The requests that lose are not consumed.
- R12: Line-coding state is never reset between words. Each word toggles from the levels the previous one left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Word offered |
| tx_word | input | 18 | Word to send |
| tx_is_ctrl | input | 1 | 1 marks the word as control (reverse strobe order) |
| seq_reset_req | input | 1 | Request a line-coding restart sequence |
| seq_status_req | input | 1 | Request a link-status sequence |
| tx_ready | output | 1 | Idle; any present request is accepted at this edge |
| line_d | output | 5 | Data wires |
| line_sa | output | 1 | Strobe A |
| line_sb | output | 1 | Strobe B |

## Verification
Each transaction toggles the data wires from the levels the previous one left. A corrupted inversion flag, a wrong beat index or a lost wire level therefore shows at the very next strobe edge, and it stays wrong on every later beat until a restart sequence clears the wires. A wrong step counter or a wrong transaction kind shows at once, as a strobe pair out of Gray order or as the wrong number of edges before `tx_ready` returns. The bench compares every edge against its own model of the wire levels and the strobe pair. It also checks that the data wires did not change in the sample where a strobe moved.

// File: rtl/sltx_pkg.sv
package sltx_pkg;
   typedef enum logic [1:0] {
      K_DATA   = 2'd0,
      K_CTRL   = 2'd1,
      K_RESTART= 2'd2,
      K_STATUS = 2'd3
   } xact_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LAUNCH = 2'd1,
      ST_SETTLE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/sltx_bus_inv.sv
module sltx_bus_inv #(
   parameter int HALF_W = 9
) (
   input  logic [HALF_W-1:0] half_in,
   output logic [HALF_W:0]   code_out
);
   localparam int CNT_W  = $clog2(HALF_W + 1);
   localparam int THRESH = HALF_W / 2;

   logic [CNT_W-1:0] ones;
   logic             flip;

   always_comb begin
      ones = '0;
      for (int i = 0; i < HALF_W; i++)
         ones = ones + CNT_W'(half_in[i]);
   end

   assign flip     = (ones > CNT_W'(THRESH));
   assign code_out = {flip, flip ? ~half_in : half_in};
endmodule

// File: rtl/sltx_encoder.sv
module sltx_encoder #(
   parameter int HALF_W = 9
) (
   input  logic [2*HALF_W-1:0]   word_in,
   output logic [2*HALF_W+1:0]   code_out
);
   localparam int CODE_W = HALF_W + 1;

   for (genvar h = 0; h < 2; h++) begin : g_half
      sltx_bus_inv #(.HALF_W(HALF_W)) i_inv (
         .half_in (word_in[h*HALF_W +: HALF_W]),
         .code_out(code_out[h*CODE_W +: CODE_W])
      );
   end
endmodule

// File: rtl/sltx_lane_coder.sv
module sltx_lane_coder #(
   parameter int LANES   = 5,
   parameter bit NRZI_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             clear,
   input  logic [LANES-1:0] beat,
   output logic [LANES-1:0] lanes
);
   logic [LANES-1:0] lvl_q;

   if (NRZI_EN) begin : g_nrzi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     lvl_q <= '0;
         else if (clear) lvl_q <= '0;
         else if (load)  lvl_q <= lvl_q ^ beat;
      end
   end else begin : g_nrz
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     lvl_q <= '0;
         else if (clear) lvl_q <= '0;
         else if (load)  lvl_q <= beat;
      end
   end

   assign lanes = lvl_q;

   // R9 / R12: wires only move on a launch or a clear
   a_r9_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clear) |=> $stable(lanes));

   // R8: a clear always leaves the wires at zero
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (lanes == '0));
endmodule

// File: rtl/sltx_strobe_seq.sv
module sltx_strobe_seq
   import sltx_pkg::*;
#(
   parameter int SETUP_CYC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  xact_kind_t start_kind,
   output logic       idle,
   output logic       launch,
   output logic [1:0] step,
   output xact_kind_t cur_kind,
   output logic       stb_a,
   output logic       stb_b
);
   localparam int WCW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
   localparam logic [WCW-1:0] WLAST = WCW'(SETUP_CYC - 1);

   seq_state_t     st_q;
   logic [WCW-1:0] wcnt_q;
   logic [1:0]     step_q;
   xact_kind_t     kind_q;
   logic           a_q, b_q;
   logic           edge_now, toggle_a, last_step;

   always_comb begin
      unique case (kind_q)
         K_DATA:    toggle_a = ~step_q[0];
         K_CTRL:    toggle_a =  step_q[0];
         K_RESTART: toggle_a = 1'b1;
         default:   toggle_a = 1'b0;
      endcase
   end

   assign last_step = (kind_q == K_RESTART || kind_q == K_STATUS) ?
                      (step_q == 2'd1) : (step_q == 2'd3);
   assign edge_now  = (st_q == ST_SETTLE) && (wcnt_q == WLAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         wcnt_q <= '0;
         step_q <= '0;
         kind_q <= K_DATA;
         a_q    <= 1'b0;
         b_q    <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               st_q   <= ST_LAUNCH;
               kind_q <= start_kind;
               step_q <= '0;
            end
            ST_LAUNCH: begin
               st_q   <= ST_SETTLE;
               wcnt_q <= '0;
            end
            default: begin
               if (edge_now) begin
                  if (toggle_a) a_q <= ~a_q;
                  else          b_q <= ~b_q;
                  step_q <= step_q + 2'd1;
                  st_q   <= last_step ? ST_IDLE : ST_LAUNCH;
               end else begin
                  wcnt_q <= wcnt_q + WCW'(1);
               end
            end
         endcase
      end
   end

   assign idle     = (st_q == ST_IDLE);
   assign launch   = (st_q == ST_LAUNCH);
   assign step     = step_q;
   assign cur_kind = kind_q;
   assign stb_a    = a_q;
   assign stb_b    = b_q;

   // R10: one strobe at a time
   a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!$stable(stb_a) && !$stable(stb_b)));

   // R1: idle means both strobes low
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!stb_a && !stb_b));

   // R5: a strobe edge is always preceded by a launch cycle
   a_r5_launch_first: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !idle && $stable(stb_a) && $stable(stb_b));
endmodule

// File: rtl/strobe_link_tx.sv
module strobe_link_tx
   import sltx_pkg::*;
#(
   parameter int HALF_W    = 9,
   parameter int SETUP_CYC = 2,
   parameter bit NRZI_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_valid,
   input  logic [2*HALF_W-1:0] tx_word,
   input  logic                tx_is_ctrl,
   input  logic                seq_reset_req,
   input  logic                seq_status_req,
   output logic                tx_ready,
   output logic [(HALF_W+1)/2-1:0] line_d,
   output logic                line_sa,
   output logic                line_sb
);
   localparam int CODE_W = HALF_W + 1;
   localparam int LANES  = CODE_W / 2;
   localparam int BEATS  = (2 * CODE_W) / LANES;
   localparam int HALF_MAX_ONES = HALF_W / 2;

   if (HALF_W < 3 || (HALF_W % 2) == 0) begin : g_bad_half
      $error("strobe_link_tx: HALF_W must be odd and at least 3");
   end
   if (BEATS != 4) begin : g_bad_beats
      $error("strobe_link_tx: four beats per word are required");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("strobe_link_tx: SETUP_CYC must be at least 1");
   end

   logic [2*CODE_W-1:0] enc_w, code_q;
   logic [LANES-1:0]    beat;
   logic                idle, launch, accept;
   logic [1:0]          step;
   xact_kind_t          pick_kind, cur_kind;
   logic                lane_load, lane_clear;

   sltx_encoder #(.HALF_W(HALF_W)) i_enc (
      .word_in (tx_word),
      .code_out(enc_w)
   );

   always_comb begin
      if (seq_reset_req)       pick_kind = K_RESTART;
      else if (seq_status_req) pick_kind = K_STATUS;
      else if (tx_is_ctrl)     pick_kind = K_CTRL;
      else                     pick_kind = K_DATA;
   end

   assign accept = idle && (seq_reset_req || seq_status_req || tx_valid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= '0;
      else if (accept && !seq_reset_req && !seq_status_req)
         code_q <= enc_w;
   end

   sltx_strobe_seq #(.SETUP_CYC(SETUP_CYC)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .start_kind(pick_kind),
      .idle      (idle),
      .launch    (launch),
      .step      (step),
      .cur_kind  (cur_kind),
      .stb_a     (line_sa),
      .stb_b     (line_sb)
   );

   assign beat       = code_q[step*LANES +: LANES];
   assign lane_load  = launch && (cur_kind == K_DATA || cur_kind == K_CTRL);
   assign lane_clear = launch && (cur_kind == K_RESTART);

   sltx_lane_coder #(.LANES(LANES), .NRZI_EN(NRZI_EN)) i_lanes (
      .clk  (clk),
      .rst_n(rst_n),
      .load (lane_load),
      .clear(lane_clear),
      .beat (beat),
      .lanes(line_d)
   );

   assign tx_ready = idle;

   // R5: data wires are quiet in the cycle a strobe moves
   a_r5_lanes_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(line_sa) || !$stable(line_sb)) |-> $stable(line_d));

   // R2: each held code half carries at most half its width in ones
   a_r2_half0_light: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(code_q[HALF_W-1:0]) <= HALF_MAX_ONES);
   a_r2_half1_light: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(code_q[CODE_W +: HALF_W]) <= HALF_MAX_ONES);

   // R8: restart edges see zeroed wires
   a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_kind == K_RESTART && !$stable(line_sa)) |-> (line_d == '0));

   // R1: ready drops after acceptance
   a_r1_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !tx_ready);
endmodule

// File: tb/test_strobe_link_tx.sv
module test_strobe_link_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_valid = 1'b0;
   logic [17:0] tx_word = '0;
   logic        tx_is_ctrl = 1'b0;
   logic        seq_reset_req = 1'b0;
   logic        seq_status_req = 1'b0;
   logic        tx_ready;
   logic [4:0]  line_d;
   logic        line_sa, line_sb;

   int total = 0;
   int bad = 0;
   logic [4:0] lm = '0;   // model of the data wires
   bit done = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   strobe_link_tx i_strobe_link_tx (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_word(tx_word),
      .tx_is_ctrl(tx_is_ctrl), .seq_reset_req(seq_reset_req),
      .seq_status_req(seq_status_req), .tx_ready(tx_ready), .line_d(line_d),
      .line_sa(line_sa), .line_sb(line_sb)
   );

   function automatic logic [19:0] enc(input logic [17:0] w);
      logic [19:0] c;
      for (int h = 0; h < 2; h++) begin
         logic [8:0] hv;
         hv = w[h*9 +: 9];
         if ($countones(hv) > 4) c[h*10 +: 10] = {1'b1, ~hv};
         else                    c[h*10 +: 10] = {1'b0, hv};
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // kind: 0 data, 1 ctrl, 2 restart, 3 status
   task automatic run(input logic v, input logic [17:0] w, input logic c,
                      input logic rr, input logic sr);
      int kind, n_exp, k;
      logic [1:0] seq [4];
      logic [19:0] code;
      logic [1:0] ps, s;
      logic [4:0] pd;
      string rq;
      if (rr)      kind = 2;
      else if (sr) kind = 3;
      else         kind = c ? 1 : 0;
      case (kind)
         0: begin seq[0]=2'b10; seq[1]=2'b11; seq[2]=2'b01; seq[3]=2'b00; n_exp=4; rq="R6"; end
         1: begin seq[0]=2'b01; seq[1]=2'b11; seq[2]=2'b10; seq[3]=2'b00; n_exp=4; rq="R7"; end
         2: begin seq[0]=2'b10; seq[1]=2'b00; seq[2]=2'b00; seq[3]=2'b00; n_exp=2; rq="R8"; end
         default: begin seq[0]=2'b01; seq[1]=2'b00; seq[2]=2'b00; seq[3]=2'b00; n_exp=2; rq="R9"; end
      endcase
      code = enc(w);
      while (!tx_ready) @(negedge clk);
      tx_valid = v; tx_word = w; tx_is_ctrl = c; seq_reset_req = rr; seq_status_req = sr;
      ps = {line_sa, line_sb}; pd = line_d;
      @(negedge clk);
      tx_valid = 1'b0; seq_reset_req = 1'b0; seq_status_req = 1'b0;
      chk(tx_ready == 1'b0, "R1 ready low after accept", tx_ready, 0);
      k = 0;
      forever begin
         s = {line_sa, line_sb};
         if (tx_ready && s != 2'b00) chk(1'b0, "R1 ready with strobes high", s, 0);
         if (s != ps) begin
            chk(!(s[0] != ps[0] && s[1] != ps[1]), "R10 one strobe", {ps, s}, 0);
            if (k < n_exp) begin
               chk(s == seq[k], rq, s, seq[k]);
               if (kind <= 1)      lm = lm ^ code[k*5 +: 5];
               else if (kind == 2) lm = '0;
               chk(line_d == lm, (kind <= 1) ? "R3 R4 R12 wires at edge" :
                   (kind == 2 ? "R8 wires zero" : "R9 wires held"), line_d, lm);
               chk(line_d == pd, "R5 wires quiet at edge", line_d, pd);
            end
            k++;
         end
         ps = s; pd = line_d;
         if (tx_ready) break;
         @(negedge clk);
      end
      chk(k == n_exp, {rq, " R11 edge count"}, k, n_exp);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd20251);
      repeat (3) @(negedge clk);
      chk(tx_ready == 1'b1 && line_sa == 1'b0 && line_sb == 1'b0, "R1 reset strobes", {tx_ready, line_sa, line_sb}, 3'b100);
      chk(line_d == 5'd0, "R1 reset wires", line_d, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_ready == 1'b1, "R1 ready idle", tx_ready, 1);
      // R2 boundaries: 4 ones stay, 5 ones invert, all ones, all zero
      run(1, 18'h0000F, 0, 0, 0);
      run(1, 18'h0001F, 0, 0, 0);
      run(1, 18'h3FFFF, 0, 0, 0);
      run(1, 18'h00000, 0, 0, 0);
      run(1, {9'h1F0, 9'h00F}, 1, 0, 0);          // R7 control
      run(0, 18'h0, 0, 0, 1);                    // R9 status
      run(1, 18'h2A5A5, 0, 0, 0);                // R12 carry-over
      run(0, 18'h0, 0, 1, 0);                    // R8 restart
      chk(line_d == 5'd0, "R8 zero after restart", line_d, 0);
      run(1, 18'h12345, 0, 0, 0);                // R8 resumes from zero
      run(1, 18'h3C3C3, 1, 1, 1);                // R11 restart wins
      run(1, 18'h3C3C3, 1, 0, 1);                // R11 status beats word
      run(1, 18'h3C3C3, 1, 0, 0);                // R11 word then served
      for (int i = 0; i < 80; i++) begin
         int r;
         r = $urandom_range(0, 9);
         run(1, 18'($urandom), (r >= 6), (r == 9), (r == 8));
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule